// File: doc/BRIEF.md
# Parallel Configuration Data Engine

This block moves configuration words from a 32-bit data port onto a passive-parallel configuration bus. A small register file holds the transfer settings: a bus-width select (16 or 32 bits), a clock-to-data ratio and a transfer enable. Each accepted word becomes one or two bus beats. Every beat stays unchanged for a programmed number of generated data-clock (DCLK) periods, and the bus is sampled on the rising DCLK edges. A DCLK period is two system clock cycles long: one cycle low, then one cycle high.

Software can also write a pulse count. The block then emits that many DCLK pulses with no data; this is how the trailing clocks that follow a bitstream (normally 4) are produced. When the burst ends, a sticky done flag is set, and software clears it by writing a 1 to it. The last word of a bitstream may be partial. The data port takes a byte count with each word and forces the unused upper bytes to zero.

Top module: `pcfg_engine`

## Requirements
- R1: After reset the control register reads 0, the count and status registers read 0, `dat_ready` is 0 and `pp_dclk` is 0.
- R2: The control register at offset 0x4 keeps bit 9 (width: 0 = 16-bit, 1 = 32-bit), bit 8 (transfer enable) and bits [7:6] (ratio: 00 = x1, 01 = x2, 10 = x4, 11 = x8). All other bits read back as 0.
- R3: While bit 8 is 0, `dat_ready` stays 0, no word is accepted and no DCLK pulse appears.
- R4: In 32-bit mode an accepted word appears whole on `pp_data[31:0]` as a single beat.
- R5: In 16-bit mode a word is sent as two beats on `pp_data[15:0]`: bits [15:0] first, then bits [31:16]. `pp_data[31:16]` is 0 throughout.
- R6: With ratio R (1, 2, 4 or 8), each beat lasts exactly R DCLK rising edges and stays unchanged across them.
- R7: `dat_ready` is 0 from the cycle after a word is accepted until that word's last beat has finished. Back-to-back words are delivered in the order they were given.
- R8: `dat_nbytes` selects how many low bytes are kept: 1, 2 or 3 keep that many bytes and zero the rest; 0 keeps all four.
- R9: Writing N > 0 to the count register at offset 0x8 produces exactly N DCLK pulses, and `dat_ready` is 0 while they run. The register reads back N just after the write, N-1 two cycles later, and 0 when the burst is idle. Writing 0 produces no pulse and sets the done flag.
- R10: Bit 0 of the status register at offset 0xC becomes 1 two cycles after the last burst pulse has started, and not before. Writing 0 to it leaves it set; writing 1 clears it.
- R11: A count write made while a burst or a word transfer is in progress is ignored. The pulse total and the done flag are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register byte offset, used for both writes and reads |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for the register at `cfg_addr` |
| dat_valid | input | 1 | A configuration word is offered |
| dat_word | input | 32 | Configuration word |
| dat_nbytes | input | 2 | Valid low bytes of the word; 0 means all four |
| dat_ready | output | 1 | The word is taken on this cycle's clock edge if `dat_valid` is 1 |
| pp_dclk | output | 1 | Generated configuration clock |
| pp_data | output | 32 | Configuration bus data |

## Verification
The hardest cases to reach are the ignored count writes. One lands in the middle of a pulse burst. The other lands while a word is still being serialised at ratio x8, because that is the only state in which the word path can still block the burst path. The bench counts DCLK rising edges with a monitor and records the bus value at each edge. It issues the second write a fixed number of cycles into the first activity, so the edge totals, the recorded beats and the done flag show whether the write was dropped. The exact cycle at which the done flag sets is checked by sampling the status register one cycle before and one cycle after that point.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  localparam int DATA_W  = 32;
  localparam int HALF_W  = DATA_W / 2;
  localparam int RATIO_W = 2;
  localparam int SUB_W   = 1 << RATIO_W;   // holds 2 * 2^(2^RATIO_W - 1) ticks
  localparam int CNT_W   = 16;
  localparam int ADDR_W  = 4;

  localparam logic [ADDR_W-1:0] OFS_CTL = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CNT = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_STS = 4'hC;

  localparam int BIT_WIDE  = 9;
  localparam int BIT_EN    = 8;
  localparam int BIT_RATIO = 6;

  typedef struct packed {
    logic               wide;
    logic               en;
    logic [RATIO_W-1:0] ratio;
  } ctl_t;

  // system clock ticks spent on one beat: 2 per DCLK period, 2^ratio periods
  function automatic logic [SUB_W:0] beat_ticks(input logic [RATIO_W-1:0] r);
    return (SUB_W+1)'(2) << r;
  endfunction

  // keep only the valid low bytes of a word; 0 means all bytes valid
  function automatic logic [DATA_W-1:0] keep_bytes(input logic [DATA_W-1:0] w,
                                                   input logic [1:0] nb);
    case (nb)
      2'd1:    return w & 32'h0000_00FF;
      2'd2:    return w & 32'h0000_FFFF;
      2'd3:    return w & 32'h00FF_FFFF;
      default: return w;
    endcase
  endfunction
endpackage

// File: rtl/pcfg_regs.sv
module pcfg_regs
  import pcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              burst_fin,
  input  logic [CNT_W-1:0]  remain,
  output ctl_t              ctl,
  output logic              cnt_wr,
  output logic [DATA_W-1:0] rdata
);
  logic done_q;
  logic sts_clr;
  logic unused_bits;

  assign cnt_wr      = wr && (addr == OFS_CNT);
  assign sts_clr     = wr && (addr == OFS_STS) && wdata[0];
  assign unused_bits = ^{wdata[DATA_W-1:BIT_WIDE+1], wdata[BIT_RATIO-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl    <= '0;
      done_q <= 1'b0;
    end else begin
      if (wr && addr == OFS_CTL)
        ctl <= '{wide: wdata[BIT_WIDE], en: wdata[BIT_EN],
                 ratio: wdata[BIT_RATIO +: RATIO_W]};
      if (burst_fin)      done_q <= 1'b1;   // a finishing burst wins over a clear
      else if (sts_clr)   done_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTL: begin
        rdata[BIT_WIDE]               = ctl.wide;
        rdata[BIT_EN]                 = ctl.en;
        rdata[BIT_RATIO +: RATIO_W]   = ctl.ratio;
      end
      OFS_CNT: rdata[CNT_W-1:0] = remain;
      OFS_STS: rdata[0]         = done_q;
      default: rdata = '0;
    endcase
  end

  AST_DONE_ON_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    burst_fin |=> done_q); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !sts_clr) |=> done_q); // R10
endmodule

// File: rtl/pcfg_burst.sv
module pcfg_burst
  import pcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             blocked,
  output logic             active,
  output logic             dclk,
  output logic [CNT_W-1:0] remain,
  output logic             fin
);
  logic phase_q;
  logic take;
  logic last_pulse;

  assign take       = start && !active && !blocked;
  assign last_pulse = active && phase_q && (remain == CNT_W'(1));
  assign fin        = last_pulse || (take && count == '0);
  assign dclk       = active && phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      phase_q <= 1'b0;
      remain  <= '0;
    end else if (take && count != '0) begin
      active  <= 1'b1;
      phase_q <= 1'b0;
      remain  <= count;
    end else if (active) begin
      phase_q <= !phase_q;
      if (phase_q) begin
        remain <= remain - 1'b1;
        if (last_pulse) active <= 1'b0;
      end
    end
  end

  AST_REM_NEVER_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (remain <= $past(remain))); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (remain == '0)); // R9
endmodule

// File: rtl/pcfg_ser.sv
module pcfg_ser
  import pcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic              blocked,
  input  logic              dat_valid,
  input  logic [DATA_W-1:0] dat_word,
  input  logic [1:0]        dat_nbytes,
  output logic              ready,
  output logic              accept,
  output logic              busy,
  output logic              dclk,
  output logic [DATA_W-1:0] bus_data
);
  logic               wide_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [DATA_W-1:0]  word_q;
  logic               hi_q;
  logic [SUB_W-1:0]   sub_q;
  logic               sub_last;
  logic               beat_last;

  assign ready     = ctl.en && !busy && !blocked;
  assign accept    = ready && dat_valid;
  assign sub_last  = ({1'b0, sub_q} == beat_ticks(ratio_q) - 1'b1);
  assign beat_last = wide_q || hi_q;
  assign dclk      = busy && sub_q[0];
  assign bus_data  = wide_q ? word_q
                            : {{HALF_W{1'b0}}, hi_q ? word_q[DATA_W-1:HALF_W]
                                                    : word_q[HALF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      wide_q  <= 1'b0;
      ratio_q <= '0;
      word_q  <= '0;
      hi_q    <= 1'b0;
      sub_q   <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      wide_q  <= ctl.wide;
      ratio_q <= ctl.ratio;
      word_q  <= keep_bytes(dat_word, dat_nbytes);
      hi_q    <= 1'b0;
      sub_q   <= '0;
    end else if (busy) begin
      if (!sub_last) begin
        sub_q <= sub_q + 1'b1;
      end else if (beat_last) begin
        busy  <= 1'b0;
        sub_q <= '0;
      end else begin
        hi_q  <= 1'b1;
        sub_q <= '0;
      end
    end
  end

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sub_last) |=> $stable(bus_data)); // R6
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !ready)); // R7
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wide_q) |-> (bus_data[DATA_W-1:HALF_W] == '0)); // R5
endmodule

// File: rtl/pcfg_engine.sv
module pcfg_engine
  import pcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              dat_valid,
  input  logic [DATA_W-1:0] dat_word,
  input  logic [1:0]        dat_nbytes,
  output logic              dat_ready,
  output logic              pp_dclk,
  output logic [DATA_W-1:0] pp_data
);
  ctl_t             ctl;
  logic             cnt_wr;
  logic             burst_active;
  logic             burst_dclk;
  logic             burst_fin;
  logic [CNT_W-1:0] burst_remain;
  logic             ser_accept;
  logic             ser_busy;
  logic             ser_dclk;

  pcfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .burst_fin(burst_fin), .remain(burst_remain), .ctl(ctl), .cnt_wr(cnt_wr),
    .rdata(cfg_rdata)
  );

  pcfg_burst u_burst (
    .clk(clk), .rst_n(rst_n), .start(cnt_wr), .count(cfg_wdata[CNT_W-1:0]),
    .blocked(ser_busy || ser_accept), .active(burst_active), .dclk(burst_dclk),
    .remain(burst_remain), .fin(burst_fin)
  );

  pcfg_ser u_ser (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .blocked(burst_active),
    .dat_valid(dat_valid), .dat_word(dat_word), .dat_nbytes(dat_nbytes),
    .ready(dat_ready), .accept(ser_accept), .busy(ser_busy), .dclk(ser_dclk),
    .bus_data(pp_data)
  );

  assign pp_dclk = ser_dclk || burst_dclk;

  AST_PATHS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_busy && burst_active)); // R11
  AST_NO_ACCEPT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && !ctl.en) |=> !ser_busy || $past(ser_busy)); // R3
endmodule

// File: tb/pcfg_engine_test.sv
module pcfg_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        dat_valid = 1'b0;
  logic [31:0] dat_word = '0;
  logic [1:0]  dat_nbytes = '0;
  logic        dat_ready;
  logic        pp_dclk;
  logic [31:0] pp_data;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int nlog = 0;
  logic [31:0] lg [0:63];
  logic prev_dclk = 1'b0;

  pcfg_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dat_valid(dat_valid),
    .dat_word(dat_word), .dat_nbytes(dat_nbytes), .dat_ready(dat_ready),
    .pp_dclk(pp_dclk), .pp_data(pp_data)
  );

  always #2 clk = ~clk;

  // record the bus on every DCLK rising edge, sampled away from the clock edge
  always @(negedge clk) begin
    if (pp_dclk && !prev_dclk) begin
      if (nlog < 64) lg[nlog] = pp_data;
      nlog = nlog + 1;
    end
    prev_dclk = pp_dclk;
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic push(input logic [31:0] w, input logic [1:0] nb);
    @(negedge clk);
    dat_valid = 1'b1; dat_word = w; dat_nbytes = nb;
    while (!dat_ready) @(negedge clk);
    @(negedge clk);
    dat_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (!dat_ready && n < 400) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl_val(input bit wide, input bit en, input int r);
    return (32'(wide) << 9) | (32'(en) << 8) | (32'(r) << 6);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    reg_read(4'h4, v); check("R1 ctl", v, 0);
    reg_read(4'h8, v); check("R1 count", v, 0);
    reg_read(4'hC, v); check("R1 status", v, 0);
    check("R1 ready", 32'(dat_ready), 0);
    check("R1 dclk", 32'(pp_dclk), 0);
  endtask

  task automatic t_ctl_fields();
    logic [31:0] v;
    reg_write(4'h4, 32'hFFFF_FFFF);
    reg_read(4'h4, v); check("R2 all ones", v, 32'h0000_03C0);
    reg_write(4'h4, 32'h0000_0280);
    reg_read(4'h4, v); check("R2 wide x4", v, 32'h0000_0280);
    reg_write(4'h4, 0);
  endtask

  task automatic t_disabled();
    int seen = 0;
    nlog = 0;
    reg_write(4'h4, ctl_val(1, 0, 0));
    dat_valid = 1'b1; dat_word = 32'h1234_5678; dat_nbytes = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (dat_ready) seen++;
    end
    dat_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 ready while disabled", 32'(seen), 0);
    check("R3 no dclk while disabled", 32'(nlog), 0);
  endtask

  task automatic t_wide32();
    reg_write(4'h4, ctl_val(1, 1, 0));
    nlog = 0;
    push(32'hDEAD_BEEF, 0);
    wait_idle();
    check("R4 edges", 32'(nlog), 1);
    check("R4 word", lg[0], 32'hDEAD_BEEF);
  endtask

  task automatic t_half16();
    reg_write(4'h4, ctl_val(0, 1, 2));
    nlog = 0;
    push(32'hA5C3_1E7F, 0);
    wait_idle();
    check("R5 edges", 32'(nlog), 8);
    check("R5 low half first", lg[0], 32'h0000_1E7F);
    check("R5 low half held", lg[3], 32'h0000_1E7F);
    check("R5 high half second", lg[4], 32'h0000_A5C3);
    check("R5 high half held", lg[7], 32'h0000_A5C3);
  endtask

  task automatic t_ratios();
    for (int r = 0; r < 4; r++) begin
      logic [31:0] w;
      int diff;
      w = 32'h0F1E_2D3C ^ (32'(r) << 28);
      reg_write(4'h4, ctl_val(1, 1, r));
      nlog = 0;
      push(w, 0);
      wait_idle();
      check("R6 edges per beat", 32'(nlog), 32'(1 << r));
      diff = 0;
      for (int k = 0; k < nlog; k++) if (lg[k] !== w) diff++;
      check("R6 beat stable", 32'(diff), 0);
    end
  endtask

  task automatic t_backpressure();
    reg_write(4'h4, ctl_val(1, 1, 3));
    nlog = 0;
    push(32'h1111_2222, 0);
    check("R7 ready low after accept", 32'(dat_ready), 0);
    push(32'h3333_4444, 0);
    wait_idle();
    check("R7 total edges", 32'(nlog), 16);
    check("R7 first word", lg[0], 32'h1111_2222);
    check("R7 second word", lg[8], 32'h3333_4444);
  endtask

  task automatic t_partial();
    reg_write(4'h4, ctl_val(1, 1, 0));
    nlog = 0;
    push(32'hCAFE_F00D, 1);
    push(32'hCAFE_F00D, 2);
    push(32'hCAFE_F00D, 3);
    wait_idle();
    check("R8 one byte", lg[0], 32'h0000_000D);
    check("R8 two bytes", lg[1], 32'h0000_F00D);
    check("R8 three bytes", lg[2], 32'h00FE_F00D);
  endtask

  task automatic t_burst();
    logic [31:0] v;
    int blocked = 0;
    reg_write(4'h4, ctl_val(1, 1, 0));
    reg_write(4'hC, 1);
    nlog = 0;
    reg_write(4'h8, 5);
    reg_read(4'h8, v); check("R9 count readback", v, 5);
    repeat (2) @(negedge clk);
    reg_read(4'h8, v); check("R9 count after one pulse", v, 4);
    dat_valid = 1'b1; dat_word = 32'h5555_AAAA; dat_nbytes = 0;
    #1;
    if (dat_ready) blocked++;
    dat_valid = 1'b0;
    check("R9 data port blocked", 32'(blocked), 0);
    repeat (12) @(negedge clk);
    check("R9 pulse count", 32'(nlog), 5);
    reg_read(4'h8, v); check("R9 idle count", v, 0);
    reg_write(4'hC, 1);
    nlog = 0;
    reg_write(4'h8, 0);
    reg_read(4'hC, v); check("R9 zero count done", v, 1);
    repeat (3) @(negedge clk);
    check("R9 zero count no pulse", 32'(nlog), 0);
    reg_write(4'hC, 1);
  endtask

  task automatic t_done();
    logic [31:0] v;
    reg_write(4'h8, 3);
    repeat (5) @(negedge clk);
    reg_read(4'hC, v); check("R10 not yet done", v, 0);
    @(negedge clk);
    reg_read(4'hC, v); check("R10 done on time", v, 1);
    reg_write(4'hC, 0);
    reg_read(4'hC, v); check("R10 write 0 keeps", v, 1);
    reg_write(4'hC, 1);
    reg_read(4'hC, v); check("R10 write 1 clears", v, 0);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    nlog = 0;
    reg_write(4'h8, 6);
    repeat (3) @(negedge clk);
    reg_write(4'h8, 20);
    repeat (30) @(negedge clk);
    check("R11 burst write ignored", 32'(nlog), 6);
    reg_write(4'hC, 1);
    reg_write(4'h4, ctl_val(1, 1, 3));
    nlog = 0;
    push(32'h7777_8888, 0);
    reg_write(4'h8, 3);
    wait_idle();
    repeat (10) @(negedge clk);
    check("R11 busy write ignored", 32'(nlog), 8);
    reg_read(4'hC, v); check("R11 done untouched", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctl_fields();
    t_disabled();
    t_wide32();
    t_half16();
    t_ratios();
    t_backpressure();
    t_partial();
    t_burst();
    t_done();
    t_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule